// File: doc/BRIEF.md
# MESI Line Coherence Controller

This block keeps the coherence state of one cache line in a snooping MESI cache that sits on a shared atomic bus. Processor reads and writes are checked against the line state. A hit is served locally. A write to an Exclusive line upgrades the line to Modified without any bus traffic. Any other case raises a bus request to an external arbiter, and the processor stays stalled until the request completes. Transactions that other caches place on the bus are snooped every cycle. They move the line toward Shared or Invalid, and they raise a flush strobe when this cache owns dirty data.

The key property is that a request waiting for the grant is never stale. The command offered to the arbiter is derived each cycle from the pending access kind and the live line state. Suppose a write is queued as an upgrade and another cache invalidates the line before the grant arrives. The offered command then becomes a read-exclusive, which waits for a data response before the line enters Modified. The data path is reduced to a data-valid input and a flush output.

The sequencer has three states:
- ST_IDLE: it accepts requests.
- ST_WAIT_GNT: it drives the request.
- ST_WAIT_DATA: it waits for the fill.

Its transitions are:
- IDLE→WAIT_GNT: an access needs the bus.
- WAIT_GNT→IDLE: an upgrade is granted and completes at once.
- WAIT_GNT→WAIT_DATA: a read or read-exclusive is granted.
- WAIT_DATA→IDLE: data is valid and the line is filled.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset the line state is Invalid (encoding I=00, S=01, E=10, M=11), busy, bus request and flush are low, and the bus command output is 00 (commands: 00 none, 01 BusRd, 10 BusRdX, 11 BusUpg).
- R2: A read to an Invalid line offers BusRd (01) from the cycle after the access until a grant. After the grant it waits for data-valid, then fills to Exclusive when shared_in is low or to Shared when shared_in is high at that cycle.
- R3: A write to an Invalid line offers BusRdX (10). After the grant the line stays Invalid until data-valid, and it becomes Modified in the cycle after data-valid.
- R4: A write to a Shared line offers BusUpg (11). In the cycle after the grant the line is Modified and busy is low, with no data response involved.
- R5: A write to an Exclusive line becomes Modified on the next cycle without any bus request. A read hit, or a write to a Modified line, changes nothing and raises no request.
- R6: A snooped BusRd on a Modified line raises flush in the same cycle and moves the line to Shared. A snooped BusRd on an Exclusive line moves it to Shared without flush.
- R7: A snooped BusRdX moves a valid line to Invalid. Flush is raised in that cycle only if the line was Modified.
- R8: A snooped BusUpg on a Shared line moves it to Invalid without flush.
- R9: If the line is invalidated by a snoop while a write waits for the grant as BusUpg, the offered command changes to BusRdX (10) from the next cycle. After the grant the line becomes Modified only after data-valid.
- R10: The bus command is never BusUpg while the line is Invalid.
- R11: Busy is high in every cycle the sequencer is outside ST_IDLE, from the cycle after an access that needs the bus until the cycle after it completes. Bus request is high only in ST_WAIT_GNT.
- R12: An access and a snoop in the same idle cycle are judged against the line state after the snoop. For example, a write to an Exclusive line together with a snooped BusRd offers BusUpg. A read to a Modified line together with a snooped BusRdX flushes and then offers BusRd.
- R13: A grant that arrives in the same cycle as a snooped transaction is not taken. The request stays pending with the same command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_rd | input | 1 | Processor read access, one-cycle pulse, accepted while busy is low |
| cpu_wr | input | 1 | Processor write access, one-cycle pulse, takes priority over read |
| cpu_busy | output | 1 | Processor stall |
| bus_req | output | 1 | Request to the bus arbiter |
| bus_cmd_out | output | 2 | Command offered with the request |
| bus_gnt | input | 1 | Grant from the arbiter |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Command of the snooped transaction |
| shared_in | input | 1 | Another cache holds the line, sampled at data-valid |
| data_valid | input | 1 | Data response for a granted read or read-exclusive |
| flush | output | 1 | This cache supplies dirty data for the snooped transaction |
| line_state | output | 2 | Current MESI state of the line |

## Verification
Two pairs of functions can coincide in one cycle. The first is a processor access arriving in the same idle cycle as a snoop. The bench provokes it in two ways: a write to an Exclusive line together with a snooped BusRd, and a read to a Modified line together with a snooped BusRdX. It judges the result by the same-cycle flush and by the command offered on the next cycle, which must follow the post-snoop state. The second is a snoop landing while an upgrade is pending. Here the bench checks that the offered command turns into BusRdX and that a grant arriving together with a snoop leaves the request in place.

// File: rtl/coh_pkg.sv
package coh_pkg;

    localparam int STATE_W = 2;
    localparam int CMD_W   = 2;

    typedef enum logic [STATE_W-1:0] {
        LS_INV = 2'b00,
        LS_SHR = 2'b01,
        LS_EXC = 2'b10,
        LS_MOD = 2'b11
    } line_state_t;

    typedef enum logic [CMD_W-1:0] {
        CMD_NONE = 2'b00,
        CMD_RD   = 2'b01,
        CMD_RDX  = 2'b10,
        CMD_UPG  = 2'b11
    } bus_cmd_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT_GNT,
        ST_WAIT_DATA
    } seq_state_t;

endpackage

// File: rtl/mesi_snoop_xfer.sv
module mesi_snoop_xfer
    import coh_pkg::*;
(
    input  line_state_t cur_state,
    input  logic        snp_valid,
    input  bus_cmd_t    snp_cmd,
    output line_state_t nxt_state,
    output logic        flush_o
);

    always_comb begin
        nxt_state = cur_state;
        flush_o   = 1'b0;
        if (snp_valid) begin
            unique case (snp_cmd)
                CMD_RD: begin
                    if (cur_state == LS_MOD) begin
                        flush_o   = 1'b1;
                        nxt_state = LS_SHR;
                    end else if (cur_state == LS_EXC) begin
                        nxt_state = LS_SHR;
                    end
                end
                CMD_RDX: begin
                    flush_o   = (cur_state == LS_MOD);
                    nxt_state = LS_INV;
                end
                CMD_UPG: begin
                    nxt_state = LS_INV;
                end
                CMD_NONE: begin
                    nxt_state = cur_state;
                end
            endcase
        end
    end

endmodule

// File: rtl/mesi_cpu_decode.sv
module mesi_cpu_decode
    import coh_pkg::*;
(
    input  logic        cpu_rd,
    input  logic        cpu_wr,
    input  line_state_t eff_state,
    output logic        need_bus,
    output logic        kind_wr,
    output logic        silent_upg
);

    always_comb begin
        need_bus   = 1'b0;
        kind_wr    = 1'b0;
        silent_upg = 1'b0;
        if (cpu_wr) begin
            kind_wr = 1'b1;
            unique case (eff_state)
                LS_INV:  need_bus   = 1'b1;
                LS_SHR:  need_bus   = 1'b1;
                LS_EXC:  silent_upg = 1'b1;
                LS_MOD:  need_bus   = 1'b0;
            endcase
        end else if (cpu_rd) begin
            need_bus = (eff_state == LS_INV);
        end
    end

endmodule

// File: rtl/mesi_req_pick.sv
module mesi_req_pick
    import coh_pkg::*;
(
    input  logic        pend_wr,
    input  line_state_t cur_state,
    output bus_cmd_t    cmd
);

    always_comb begin
        if (!pend_wr) begin
            cmd = CMD_RD;
        end else if (cur_state == LS_SHR) begin
            cmd = CMD_UPG;
        end else begin
            cmd = CMD_RDX;
        end
    end

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
    import coh_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_rd,
    input  logic               cpu_wr,
    output logic               cpu_busy,
    output logic               bus_req,
    output logic [CMD_W-1:0]   bus_cmd_out,
    input  logic               bus_gnt,
    input  logic               snp_valid,
    input  logic [CMD_W-1:0]   snp_cmd,
    input  logic               shared_in,
    input  logic               data_valid,
    output logic               flush,
    output logic [STATE_W-1:0] line_state
);

    seq_state_t  seq_q, seq_d;
    line_state_t line_q, line_d;
    logic        pend_wr_q, pend_wr_d;

    line_state_t snp_state;
    logic        snp_flush;
    logic        need_bus, kind_wr, silent_upg;
    bus_cmd_t    pick_cmd;
    logic        take_gnt;

    mesi_snoop_xfer u_snoop (
        .cur_state (line_q),
        .snp_valid (snp_valid),
        .snp_cmd   (bus_cmd_t'(snp_cmd)),
        .nxt_state (snp_state),
        .flush_o   (snp_flush)
    );

    mesi_cpu_decode u_decode (
        .cpu_rd     (cpu_rd),
        .cpu_wr     (cpu_wr),
        .eff_state  (snp_state),
        .need_bus   (need_bus),
        .kind_wr    (kind_wr),
        .silent_upg (silent_upg)
    );

    mesi_req_pick u_pick (
        .pend_wr   (pend_wr_q),
        .cur_state (line_q),
        .cmd       (pick_cmd)
    );

    // the atomic bus carries one transaction per cycle; a snoop wins
    assign take_gnt = bus_gnt && !snp_valid;

    always_comb begin
        seq_d     = seq_q;
        line_d    = snp_state;
        pend_wr_d = pend_wr_q;
        unique case (seq_q)
            ST_IDLE: begin
                if (need_bus) begin
                    seq_d     = ST_WAIT_GNT;
                    pend_wr_d = kind_wr;
                end else if (silent_upg) begin
                    line_d = LS_MOD;
                end
            end
            ST_WAIT_GNT: begin
                if (take_gnt) begin
                    if (pick_cmd == CMD_UPG) begin
                        line_d = LS_MOD;
                        seq_d  = ST_IDLE;
                    end else begin
                        seq_d = ST_WAIT_DATA;
                    end
                end
            end
            ST_WAIT_DATA: begin
                if (data_valid) begin
                    seq_d = ST_IDLE;
                    if (pend_wr_q) begin
                        line_d = LS_MOD;
                    end else begin
                        line_d = shared_in ? LS_SHR : LS_EXC;
                    end
                end
            end
            default: seq_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q     <= ST_IDLE;
            line_q    <= LS_INV;
            pend_wr_q <= 1'b0;
        end else begin
            seq_q     <= seq_d;
            line_q    <= line_d;
            pend_wr_q <= pend_wr_d;
        end
    end

    always_comb begin
        bus_req     = (seq_q == ST_WAIT_GNT);
        bus_cmd_out = bus_req ? pick_cmd : CMD_NONE;
        cpu_busy    = (seq_q != ST_IDLE);
        flush       = snp_flush;
        line_state  = line_q;
    end

    assert_no_upg_on_inv_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_cmd_out == CMD_UPG) |-> (line_q == LS_SHR));

    assert_no_mod_without_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (line_q == LS_INV && !data_valid) |=> (line_q != LS_MOD));

    assert_upg_done_at_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_gnt && !snp_valid && bus_cmd_out == CMD_UPG)
        |=> (line_q == LS_MOD && !cpu_busy));

    assert_req_implies_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> cpu_busy);

    assert_flush_needs_dirty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (line_q == LS_MOD && snp_valid));

    assert_rdx_invalidates_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_cmd == CMD_RDX && !data_valid) |=> (line_q == LS_INV));

    assert_gnt_with_snoop_held_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_gnt && snp_valid) |=> bus_req);

endmodule

// File: tb/tb_mesi_line_ctrl.sv
module tb_mesi_line_ctrl;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cpu_rd, cpu_wr, bus_gnt, snp_valid, shared_in, data_valid;
    logic [1:0] snp_cmd;
    logic       cpu_busy, bus_req, flush;
    logic [1:0] bus_cmd_out, line_state;

    int compared   = 0;
    int mismatched = 0;
    bit done       = 1'b0;

    typedef struct {
        string req;
        int    fld;
        int    exp;
    } item_t;

    item_t q[$];

    always #10 clk = ~clk;

    mesi_line_ctrl dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_rd      (cpu_rd),
        .cpu_wr      (cpu_wr),
        .cpu_busy    (cpu_busy),
        .bus_req     (bus_req),
        .bus_cmd_out (bus_cmd_out),
        .bus_gnt     (bus_gnt),
        .snp_valid   (snp_valid),
        .snp_cmd     (snp_cmd),
        .shared_in   (shared_in),
        .data_valid  (data_valid),
        .flush       (flush),
        .line_state  (line_state)
    );

    // field codes: 0 line_state, 1 busy, 2 bus_req, 3 bus_cmd, 4 flush
    function automatic void want(input string r, input int f, input int e);
        item_t it;
        it.req = r;
        it.fld = f;
        it.exp = e;
        q.push_back(it);
    endfunction

    function automatic int observe(input int f);
        case (f)
            0:       return int'(line_state);
            1:       return int'(cpu_busy);
            2:       return int'(bus_req);
            3:       return int'(bus_cmd_out);
            default: return int'(flush);
        endcase
    endfunction

    // monitor: compare every queued expectation away from the active edge
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            int    act;
            it  = q.pop_front();
            act = observe(it.fld);
            compared++;
            if (act !== it.exp) begin
                mismatched++;
                $display("FAIL %s field %0d: actual %0d expected %0d", it.req, it.fld, act, it.exp);
            end
        end
    end

    task automatic drive(input logic rd, input logic wr, input logic sv,
                         input logic [1:0] sc, input logic g,
                         input logic sh, input logic dv);
        @(posedge clk);
        #1;
        cpu_rd     = rd;
        cpu_wr     = wr;
        snp_valid  = sv;
        snp_cmd    = sc;
        bus_gnt    = g;
        shared_in  = sh;
        data_valid = dv;
    endtask

    task automatic idle();
        drive(0, 0, 0, 2'b00, 0, 0, 0);
    endtask

    // read miss to fill; caller checks the final state
    task automatic read_fill(input logic sh);
        drive(1, 0, 0, 2'b00, 0, 0, 0);
        idle();
        want("R2", 3, 1);
        drive(0, 0, 0, 2'b00, 1, 0, 0);
        drive(0, 0, 0, 2'b00, 0, sh, 1);
        idle();
    endtask

    initial begin
        repeat (4000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL R11 watchdog: actual hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        cpu_rd = 0; cpu_wr = 0; snp_valid = 0; snp_cmd = 2'b00;
        bus_gnt = 0; shared_in = 0; data_valid = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        idle();
        want("R1", 0, 0); want("R1", 1, 0); want("R1", 2, 0); want("R1", 3, 0); want("R1", 4, 0);

        // R2 read miss, fill Exclusive
        drive(1, 0, 0, 2'b00, 0, 0, 0);
        want("R11", 1, 0); want("R11", 2, 0);
        idle();
        want("R2", 2, 1); want("R2", 3, 1); want("R11", 1, 1); want("R2", 0, 0);
        drive(0, 0, 0, 2'b00, 1, 0, 0);
        want("R2", 3, 1);
        idle();
        want("R11", 2, 0); want("R11", 1, 1); want("R2", 0, 0);
        drive(0, 0, 0, 2'b00, 0, 0, 1);
        want("R2", 0, 0);
        idle();
        want("R2", 0, 2); want("R11", 1, 0);

        // R5 silent upgrade, then hits in Modified
        drive(0, 1, 0, 2'b00, 0, 0, 0);
        want("R5", 2, 0);
        idle();
        want("R5", 0, 3); want("R5", 2, 0); want("R5", 1, 0);
        drive(1, 0, 0, 2'b00, 0, 0, 0);
        idle();
        want("R5", 0, 3); want("R5", 2, 0); want("R5", 1, 0);
        drive(0, 1, 0, 2'b00, 0, 0, 0);
        idle();
        want("R5", 0, 3); want("R5", 2, 0);

        // R6 snooped BusRd on Modified
        drive(0, 0, 1, 2'b01, 0, 0, 0);
        want("R6", 4, 1);
        idle();
        want("R6", 0, 1); want("R6", 4, 0);

        // R4 upgrade from Shared
        drive(0, 1, 0, 2'b00, 0, 0, 0);
        idle();
        want("R4", 2, 1); want("R4", 3, 3); want("R11", 1, 1);
        drive(0, 0, 0, 2'b00, 1, 0, 0);
        want("R4", 3, 3);
        idle();
        want("R4", 0, 3); want("R4", 1, 0); want("R4", 2, 0);

        // R7 snooped BusRdX on Modified
        drive(0, 0, 1, 2'b10, 0, 0, 0);
        want("R7", 4, 1);
        idle();
        want("R7", 0, 0); want("R7", 4, 0);

        // R2 read miss, fill Shared
        read_fill(1'b1);
        want("R2", 0, 1);

        // R8 snooped BusUpg on Shared
        drive(0, 0, 1, 2'b11, 0, 0, 0);
        want("R8", 4, 0);
        idle();
        want("R8", 0, 0);

        // R3 write miss
        drive(0, 1, 0, 2'b00, 0, 0, 0);
        idle();
        want("R3", 3, 2); want("R3", 2, 1);
        drive(0, 0, 0, 2'b00, 1, 0, 0);
        idle();
        want("R3", 0, 0); want("R3", 1, 1); want("R3", 2, 0);
        idle();
        want("R3", 0, 0); want("R3", 1, 1);
        drive(0, 0, 0, 2'b00, 0, 0, 1);
        idle();
        want("R3", 0, 3); want("R3", 1, 0);

        // R7 Exclusive to Invalid without flush
        drive(0, 0, 1, 2'b10, 0, 0, 0);
        want("R7", 4, 1);
        idle();
        read_fill(1'b0);
        want("R2", 0, 2);
        drive(0, 0, 1, 2'b10, 0, 0, 0);
        want("R7", 4, 0);
        idle();
        want("R7", 0, 0);

        // R9 pending upgrade overtaken by another cache's upgrade
        read_fill(1'b1);
        want("R9", 0, 1);
        drive(0, 1, 0, 2'b00, 0, 0, 0);
        idle();
        want("R9", 3, 3); want("R9", 2, 1);
        drive(0, 0, 1, 2'b11, 0, 0, 0);
        want("R9", 4, 0); want("R9", 3, 3);
        idle();
        want("R9", 0, 0); want("R9", 3, 2); want("R9", 2, 1); want("R10", 1, 1);
        // R13 grant together with a snoop is not taken
        drive(0, 0, 1, 2'b01, 1, 0, 0);
        want("R13", 4, 0);
        idle();
        want("R13", 2, 1); want("R13", 3, 2);
        drive(0, 0, 0, 2'b00, 1, 0, 0);
        want("R9", 3, 2);
        idle();
        want("R9", 0, 0); want("R9", 1, 1); want("R9", 2, 0);
        drive(0, 0, 0, 2'b00, 0, 0, 1);
        idle();
        want("R9", 0, 3); want("R9", 1, 0);

        // R12 read on Modified with a snooped BusRdX in the same cycle
        drive(1, 0, 1, 2'b10, 0, 0, 0);
        want("R12", 4, 1);
        idle();
        want("R12", 0, 0); want("R12", 2, 1); want("R12", 3, 1);
        drive(0, 0, 0, 2'b00, 1, 0, 0);
        drive(0, 0, 0, 2'b00, 0, 0, 1);
        idle();
        want("R12", 0, 2);
        // R12 write on Exclusive with a snooped BusRd in the same cycle
        drive(0, 1, 1, 2'b01, 0, 0, 0);
        want("R6", 4, 0);
        idle();
        want("R12", 0, 1); want("R12", 2, 1); want("R12", 3, 3);
        drive(0, 0, 0, 2'b00, 1, 0, 0);
        idle();
        want("R12", 0, 3); want("R12", 1, 0); want("R12", 2, 0);

        @(negedge clk);
        #1;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule